// File: doc/BRIEF.md
# Pixel Byte Unpacker and Color Extractor

This block sits between a frame-buffer fetch engine and a display timing generator. Raw frame-buffer bytes arrive as four-byte beats on a valid/ready stream and collect in a small byte buffer. On every cycle in which the timing side raises the visible flag, the block takes one, two, three or four bytes for one pixel. It assembles them into a 32-bit word in little- or big-endian order. From that word it pulls a red, a green and a blue field, each at its own bit offset and with its own width. Fields narrower than eight bits are widened by repeating their upper bits. The result is a registered 24-bit pixel, one cycle after the visible flag.

Every channel has an 8-bit fallback color. It is driven when the channel's field width is zero, when the visible flag is low, and after a starvation. A starvation happens when the visible flag is high but the buffer holds fewer bytes than one pixel needs. The block then raises a one-cycle underrun pulse and shows fallback colors for every visible cycle up to the next frame-start pulse. It consumes no bytes during that time. After the frame-start pulse, normal output resumes with the oldest byte still held.

The input stream obeys back-pressure. A beat is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` depends only on the buffer's fill level. The source may hold `in_valid` high with stable data for as long as it wants. The pixel side has no back-pressure: the display runs at a fixed rate, and a shortage of data shows up as an underrun. Configuration inputs are expected to change only while the visible flag is low.

Top module: `pxu_top`

## Requirements
- R1: After reset, `out_pix` is 0, `out_de` is 0, `out_underrun` is 0, and `in_ready` is 1 (the buffer is empty).
- R2: A beat is stored only when `in_valid` and `in_ready` are both high at a clock edge. `in_data[7:0]` is the earliest byte of the beat and `in_data[31:24]` is the latest. `in_ready` is high exactly when the buffer has room for four more bytes.
- R3: On each cycle with `vis` high and enough buffered bytes, the block removes `cfg_bpp`+1 bytes in arrival order (`cfg_bpp` = 0..3 means 1..4 bytes). The pixel appears on `out_pix` one clock later, with `out_de` equal to the `vis` of the previous cycle.
- R4: With `cfg_big_endian` = 0, the k-th byte taken for a pixel (k counted from 0) occupies word bits [8k+7:8k]. Word bits above the bytes taken are 0.
- R5: With `cfg_big_endian` = 1 and n bytes taken, the k-th byte occupies word bits [8(n-1-k)+7 : 8(n-1-k)]. With n = 1 this gives the same word as little-endian order.
- R6: A channel with size s in 1..8 takes word bits [off+s-1:off]. Size 8 gives those bits unchanged. Red is `out_pix[23:16]`, green is `[15:8]` and blue is `[7:0]`.
- R7: For sizes 1 to 7, the s-bit field fills output bits 7 downward, most significant bit first. The field repeats from its top bit until all 8 bits are filled.
- R8: A channel with size 0 outputs its fallback color on every visible pixel.
- R9: While `vis` is low, all three channels output their fallback colors. No bytes are consumed.
- R10: A visible cycle with fewer than `cfg_bpp`+1 bytes buffered produces a single one-cycle `out_underrun` pulse, aligned with that pixel. That pixel and every later visible pixel up to the next `frame_start` show fallback colors and consume nothing, even after data arrives.
- R11: A `frame_start` pulse clears the starved state. The next visible pixel is built normally from the oldest byte still buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Four frame-buffer bytes, earliest in bits 7:0 |
| in_valid | input | 1 | Beat on `in_data` is valid |
| in_ready | output | 1 | Buffer can take a beat |
| vis | input | 1 | Visible pixel requested this cycle |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| cfg_bpp | input | 2 | Bytes per pixel minus one |
| cfg_big_endian | input | 1 | Reverse byte order within the pixel |
| cfg_r_off | input | 5 | Red field lowest bit |
| cfg_r_size | input | 4 | Red field width |
| cfg_r_dflt | input | 8 | Red fallback color |
| cfg_g_off | input | 5 | Green field lowest bit |
| cfg_g_size | input | 4 | Green field width |
| cfg_g_dflt | input | 8 | Green fallback color |
| cfg_b_off | input | 5 | Blue field lowest bit |
| cfg_b_size | input | 4 | Blue field width |
| cfg_b_dflt | input | 8 | Blue fallback color |
| out_pix | output | 24 | Registered pixel {red, green, blue} |
| out_de | output | 1 | Registered copy of `vis` |
| out_underrun | output | 1 | One-cycle starvation pulse |

## Verification
The bench targets the following cases:
- Packing formats with 1, 2, 3 and 4 bytes per pixel, with byte order reversed and not reversed. A design that mislaid a byte lane or took the wrong number of bytes would shift every later pixel.
- 5-, 6-, 3- and 2-bit fields, which exercise bit replication. A design that padded with zeros or repeated the low bits would produce wrong low-order bits.
- A zero-width channel and blanking gaps inside a visible run. A design that consumed bytes while blanking would desynchronize the stream.
- Starvation, forced by stopping the stream, followed by a refill before the frame ends. A design that resumed at once, pulsed more than once, or dropped buffered bytes would differ from the model after the next frame-start pulse.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
  localparam int BPP_W     = 2;
  localparam int MAX_BYTES = 1 << BPP_W;
  localparam int WORD_W    = MAX_BYTES * 8;
  localparam int OFF_W     = $clog2(WORD_W);
  localparam int SIZE_W    = 4;
  localparam int COMP_W    = 8;
  localparam int NCHAN     = 3;

  typedef struct packed {
    logic [OFF_W-1:0]  off;
    logic [SIZE_W-1:0] size;
    logic [COMP_W-1:0] dflt;
  } chan_cfg_t;
endpackage

// File: rtl/pxu_byte_buf.sv
`timescale 1ns/1ps
module pxu_byte_buf #(
  parameter int DEPTH = 16,
  parameter int BEAT  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [BEAT*8-1:0]            wr_data,
  input  logic [$clog2(BEAT+1)-1:0]    rd_cnt,
  output logic [BEAT*8-1:0]            peek,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         space_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // byte storage, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < BEAT; i++) begin
        mem[wr_ptr + AW'(i)] <= wr_data[i*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(BEAT);
      rd_ptr <= rd_ptr + AW'(rd_cnt);
      level  <= level + (wr_en ? CW'(BEAT) : CW'(0)) - CW'(rd_cnt);
    end
  end

  // oldest BEAT bytes visible without a read
  for (genvar g = 0; g < BEAT; g++) begin : g_peek
    assign peek[g*8 +: 8] = mem[rd_ptr + AW'(g)];
  end

  assign space_ok = (CW'(DEPTH) - level) >= CW'(BEAT);
endmodule

// File: rtl/pxu_word_form.sv
`timescale 1ns/1ps
module pxu_word_form #(
  parameter int NB = 4
) (
  input  logic [NB*8-1:0]         bytes_in,
  input  logic [$clog2(NB)-1:0]   nbm1,
  input  logic                    big_end,
  output logic [NB*8-1:0]         word
);
  int pos;

  always_comb begin
    word = '0;
    pos  = 0;
    for (int i = 0; i < NB; i++) begin
      if (i <= int'(nbm1)) begin
        pos = big_end ? (int'(nbm1) - i) : i;
        word[pos*8 +: 8] = bytes_in[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/pxu_chan_extract.sv
`timescale 1ns/1ps
module pxu_chan_extract
  import pxu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  chan_cfg_t         cfg,
  input  logic              use_dflt,
  output logic [COMP_W-1:0] comp
);
  logic [WORD_W-1:0] field;
  logic [COMP_W-1:0] rep;
  logic [2:0]        idx;

  always_comb begin
    field = word >> cfg.off;
    idx   = cfg.size[2:0] - 3'd1;
    rep   = '0;
    // walk output bits downward, cycling through the field from its top bit
    for (int j = COMP_W - 1; j >= 0; j--) begin
      rep[j] = field[idx];
      if (idx == 3'd0) idx = cfg.size[2:0] - 3'd1;
      else             idx = idx - 3'd1;
    end

    if (use_dflt || cfg.size == '0)           comp = cfg.dflt;
    else if (cfg.size >= SIZE_W'(COMP_W))     comp = field[COMP_W-1:0];
    else                                      comp = rep;
  end
endmodule

// File: rtl/pxu_top.sv
`timescale 1ns/1ps
module pxu_top
  import pxu_pkg::*;
#(
  parameter int BUF_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 vis,
  input  logic                 frame_start,
  input  logic [BPP_W-1:0]     cfg_bpp,
  input  logic                 cfg_big_endian,
  input  logic [OFF_W-1:0]     cfg_r_off,
  input  logic [SIZE_W-1:0]    cfg_r_size,
  input  logic [COMP_W-1:0]    cfg_r_dflt,
  input  logic [OFF_W-1:0]     cfg_g_off,
  input  logic [SIZE_W-1:0]    cfg_g_size,
  input  logic [COMP_W-1:0]    cfg_g_dflt,
  input  logic [OFF_W-1:0]     cfg_b_off,
  input  logic [SIZE_W-1:0]    cfg_b_size,
  input  logic [COMP_W-1:0]    cfg_b_dflt,
  output logic [NCHAN*COMP_W-1:0] out_pix,
  output logic                 out_de,
  output logic                 out_underrun
);
  localparam int CW  = $clog2(BUF_DEPTH+1);
  localparam int RCW = $clog2(MAX_BYTES+1);

  logic [WORD_W-1:0] peek, word;
  logic [CW-1:0]     level;
  logic              space_ok, wr_en;
  logic [RCW-1:0]    need, rd_cnt;
  logic              starved_q, starved_eff, short_data, take, new_starve;
  chan_cfg_t         ccfg [NCHAN];
  logic [COMP_W-1:0] comp [NCHAN];
  logic [NCHAN*COMP_W-1:0] pix_d;

  assign in_ready = space_ok;
  assign wr_en    = in_valid && space_ok;

  pxu_byte_buf #(.DEPTH(BUF_DEPTH), .BEAT(MAX_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(in_data),
    .rd_cnt(rd_cnt), .peek(peek), .level(level), .space_ok(space_ok)
  );

  // pixel demand and starvation control
  assign need        = RCW'(cfg_bpp) + RCW'(1);
  assign starved_eff = starved_q && !frame_start;
  assign short_data  = level < CW'(need);
  assign take        = vis && !starved_eff && !short_data;
  assign new_starve  = vis && !starved_eff && short_data;
  assign rd_cnt      = take ? need : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) starved_q <= 1'b0;
    else        starved_q <= starved_eff || new_starve;
  end

  pxu_word_form #(.NB(MAX_BYTES)) u_form (
    .bytes_in(peek), .nbm1(cfg_bpp), .big_end(cfg_big_endian), .word(word)
  );

  assign ccfg[0] = '{off: cfg_r_off, size: cfg_r_size, dflt: cfg_r_dflt};
  assign ccfg[1] = '{off: cfg_g_off, size: cfg_g_size, dflt: cfg_g_dflt};
  assign ccfg[2] = '{off: cfg_b_off, size: cfg_b_size, dflt: cfg_b_dflt};

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    pxu_chan_extract u_ext (
      .word(word), .cfg(ccfg[c]), .use_dflt(!take), .comp(comp[c])
    );
    // channel 0 lands in the top byte
    assign pix_d[(NCHAN-1-c)*COMP_W +: COMP_W] = comp[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_pix      <= '0;
      out_de       <= 1'b0;
      out_underrun <= 1'b0;
    end else begin
      out_pix      <= pix_d;
      out_de       <= vis;
      out_underrun <= new_starve;
    end
  end
endmodule

// File: rtl/pxu_checker.sv
`timescale 1ns/1ps
module pxu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vis,
  input logic        frame_start,
  input logic [3:0]  cfg_r_size,
  input logic [7:0]  cfg_r_dflt,
  input logic [7:0]  cfg_g_dflt,
  input logic [7:0]  cfg_b_dflt,
  input logic [23:0] out_pix,
  input logic        out_de,
  input logic        out_underrun
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_de_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> out_de == $past(vis));

  p_blank_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !out_de) |-> out_pix == $past({cfg_r_dflt, cfg_g_dflt, cfg_b_dflt}));

  p_size0_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_de && $past(cfg_r_size) == 4'd0) |-> out_pix[23:16] == $past(cfg_r_dflt));

  p_underrun_default_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && out_underrun) |-> out_pix == $past({cfg_r_dflt, cfg_g_dflt, cfg_b_dflt}));

  p_underrun_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_underrun && !frame_start) |=> !out_underrun);
endmodule

bind pxu_top pxu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vis(vis), .frame_start(frame_start),
  .cfg_r_size(cfg_r_size), .cfg_r_dflt(cfg_r_dflt), .cfg_g_dflt(cfg_g_dflt),
  .cfg_b_dflt(cfg_b_dflt), .out_pix(out_pix), .out_de(out_de),
  .out_underrun(out_underrun)
);

// File: tb/sim_pxu_top.sv
`timescale 1ns/1ps
module sim_pxu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        vis = 1'b0;
  logic        frame_start = 1'b0;
  logic [1:0]  cfg_bpp = '0;
  logic        cfg_big_endian = 1'b0;
  logic [4:0]  cfg_r_off = '0, cfg_g_off = '0, cfg_b_off = '0;
  logic [3:0]  cfg_r_size = '0, cfg_g_size = '0, cfg_b_size = '0;
  logic [7:0]  cfg_r_dflt = 8'h11, cfg_g_dflt = 8'h22, cfg_b_dflt = 8'h33;
  logic [23:0] out_pix;
  logic        out_de, out_underrun;

  always #4 clk = ~clk;

  pxu_top u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .vis(vis), .frame_start(frame_start),
    .cfg_bpp(cfg_bpp), .cfg_big_endian(cfg_big_endian),
    .cfg_r_off(cfg_r_off), .cfg_r_size(cfg_r_size), .cfg_r_dflt(cfg_r_dflt),
    .cfg_g_off(cfg_g_off), .cfg_g_size(cfg_g_size), .cfg_g_dflt(cfg_g_dflt),
    .cfg_b_off(cfg_b_off), .cfg_b_size(cfg_b_size), .cfg_b_dflt(cfg_b_dflt),
    .out_pix(out_pix), .out_de(out_de), .out_underrun(out_underrun)
  );

  typedef struct {
    logic [23:0] pix;
    logic        de;
    logic        ur;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [7:0]  bq[$];
  int          checks = 0;
  int          errors = 0;
  int          seq = 0;
  bit          feed_on = 0;
  bit          m_starved = 0;
  bit          done = 0;

  function automatic logic [7:0] bval(int k);
    return 8'((k * 53 + 17) ^ (k >> 3));
  endfunction

  function automatic logic [7:0] ref_chan(logic [31:0] w, int off, int size, logic [7:0] d);
    logic [31:0] m, f;
    int acc, bits;
    if (size == 0) return d;
    m = (32'd1 << size) - 32'd1;
    f = (w >> off) & m;
    if (size >= 8) return f[7:0];
    acc = int'(f);
    bits = size;
    while (bits < 8) begin
      acc = (acc << size) | int'(f);
      bits += size;
    end
    return 8'(acc >> (bits - 8));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one call per cycle, inputs set at the falling edge
  task automatic step(input logic v, input logic fs, input string tag);
    exp_t e;
    logic [31:0] w;
    int nb;
    @(negedge clk);
    vis = v;
    frame_start = fs;
    if (fs) m_starved = 0;
    e.de = v;
    e.ur = 1'b0;
    e.tag = tag;
    e.pix = {cfg_r_dflt, cfg_g_dflt, cfg_b_dflt};
    nb = int'(cfg_bpp) + 1;
    if (v && !m_starved) begin
      if (bq.size() < nb) begin
        m_starved = 1;
        e.ur = 1'b1;
      end else begin
        w = '0;
        for (int i = 0; i < nb; i++) begin
          logic [7:0] b;
          b = bq.pop_front();
          if (cfg_big_endian) w = w | (32'(b) << (8 * (nb - 1 - i)));
          else                w = w | (32'(b) << (8 * i));
        end
        e.pix = {ref_chan(w, int'(cfg_r_off), int'(cfg_r_size), cfg_r_dflt),
                 ref_chan(w, int'(cfg_g_off), int'(cfg_g_size), cfg_g_dflt),
                 ref_chan(w, int'(cfg_b_off), int'(cfg_b_size), cfg_b_dflt)};
      end
    end
    expq.push_back(e);
    // stream source
    in_valid = feed_on;
    in_data = {bval(seq + 3), bval(seq + 2), bval(seq + 1), bval(seq)};
    if (in_valid && in_ready) begin
      for (int i = 0; i < 4; i++) bq.push_back(bval(seq + i));
      seq += 4;
    end
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (out_pix !== e.pix || out_de !== e.de || out_underrun !== e.ur) begin
          errors++;
          $display("FAIL %s: actual pix=%h de=%b ur=%b expected pix=%h de=%b ur=%b",
                   e.tag, out_pix, out_de, out_underrun, e.pix, e.de, e.ur);
        end
      end
    end
  end

  // change configuration between edges with the block idle
  task automatic set_cfg(int bpp, bit be,
                         int ro, int rs, int go, int gs, int bo, int bs);
    @(posedge clk);
    #2;
    vis = 1'b0;
    in_valid = 1'b0;
    frame_start = 1'b0;
    cfg_bpp = 2'(bpp);
    cfg_big_endian = be;
    cfg_r_off = 5'(ro); cfg_r_size = 4'(rs);
    cfg_g_off = 5'(go); cfg_g_size = 4'(gs);
    cfg_b_off = 5'(bo); cfg_b_size = 4'(bs);
  endtask

  task automatic prefill();
    int guard = 0;
    feed_on = 1;
    while (in_ready && guard < 40) begin
      step(0, 0, "R9 blank");
      guard++;
    end
    step(0, 0, "R9 blank");
  endtask

  task automatic run(int n, int gap_every, string tag);
    for (int i = 0; i < n; i++) begin
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) step(0, 0, "R9 gap");
      else step(1, 0, tag);
    end
    step(0, 0, "R9 blank");
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 out_pix", 32'(out_pix), 32'h0);
    check("R1 out_de", 32'(out_de), 32'h0);
    check("R1 out_underrun", 32'(out_underrun), 32'h0);
    check("R1 in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;

    // R4 R6: four bytes little-endian, 8-bit fields pass through
    set_cfg(3, 0, 16, 8, 8, 8, 0, 8);
    prefill();
    check("R2 in_ready low when full", 32'(in_ready), 32'h0);
    run(20, 0, "R4 R6 le32");
    run(12, 4, "R3 le32 gaps");

    // R7: two-byte 5/6/5 packing
    set_cfg(1, 0, 11, 5, 5, 6, 0, 5);
    prefill();
    run(24, 5, "R7 le16");

    // R5 R8: three bytes big-endian, blue width zero, green 4 bits
    set_cfg(2, 1, 16, 8, 8, 4, 0, 0);
    prefill();
    run(18, 0, "R5 R8 be24");

    // R5 R7: one byte, reversal has no effect, 3/3/2 fields
    set_cfg(0, 1, 5, 3, 2, 3, 0, 2);
    prefill();
    run(16, 0, "R5 R7 be8");

    // R5: four bytes big-endian with offsets across byte lanes
    set_cfg(3, 1, 20, 7, 9, 8, 3, 1);
    prefill();
    run(10, 0, "R5 R7 be32");

    // R10: starve, refill, stay on fallback
    feed_on = 0;
    run(10, 0, "R10 starve");
    feed_on = 1;
    for (int i = 0; i < 8; i++) step(0, 0, "R9 refill");
    run(5, 0, "R10 held");

    // R11: frame start resumes with the oldest byte
    step(0, 1, "R11 frame start");
    run(8, 0, "R11 resume");

    // R10: second frame starves again with a fresh pulse
    feed_on = 0;
    run(12, 0, "R10 second frame");
    step(0, 1, "R11 frame start");
    feed_on = 1;
    prefill();
    run(6, 0, "R11 resume");

    repeat (3) @(posedge clk);
    #2;
    check("R3 scoreboard drained", 32'(expq.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule